// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Command Generator

This block produces the four gate commands of a phase-shifted full-bridge converter from a digital timebase. A reference leg (OUTA high side, OUTB low side) switches at a fixed phase. The two outputs are complementary, and each changes state once every `period` clocks, so one full switching cycle lasts `2*period` clocks. The second leg (OUTC high side, OUTD low side) has the same waveform, delayed by a commanded number of clocks. A shift of zero gives zero effective duty across the bridge. A shift equal to `period` puts the legs in antiphase, which gives full duty.

Inside each leg, an output turns on only after a dead time has passed since its complement turned off. Each leg has its own base dead time. A digital load-current code can shorten that time by up to four to one, and an adaptive-set code reduces how much the current code shortens it. A no-load detector with hysteresis watches the phase command and holds all four outputs off at light demand. The inputs that set the waveform are latched only at the end of a full switching cycle, so a new setting never cuts a pulse short.

Top module: `psfb_gate_gen`

## Requirements
- R1: With `en` high, OUTA is high in the first half and OUTB in the second half of each `2*P` clock switching cycle, where P is the latched period. OUTA repeats every `2*P` clocks, and with leg dead time d it stays high for `P-d` clocks.
- R2: OUTA and OUTB are never high together, and OUTC and OUTD are never high together.
- R3: The latched shift is S = min(phaseCmd, P). OUTC repeats the OUTA waveform delayed by S clocks, and OUTD does the same for OUTB. S = 0 puts the legs in phase, and S = P puts them in antiphase.
- R4: After an output of a leg turns off, its complement turns on exactly d clocks later, where d is that leg's effective dead time. When the dead base is 0 the complement turns on in the same clock, so insertion is defeated for that leg.
- R5: The effective dead time is floor(base*16/(16+3*k)), where k = curCode - min(adsCode, curCode), capped at 16. This gives a 4:1 range between k = 0 and k = 16.
- R6: When adsCode is equal to or above curCode, k is 0 and the full base dead time applies.
- R7: period, phaseCmd, deadAB, deadCD, curCode and adsCode are latched in the last clock of a switching cycle, or in every clock while `en` is low. A change at any other time has no effect on the outputs until that point.
- R8: A latched phaseCmd below 8 forces all four outputs low from the next clock. The outputs are released only after a latched phaseCmd above 12, and values from 8 to 12 keep the current state. After reset the outputs are held low.
- R9: With `rst_n` low, or one clock after `en` is sampled low, all four outputs are low. When enabled again the timebase restarts, and OUTA turns on before OUTB.
- R10: A period input below 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces outputs off and restarts the timebase |
| period | input | 8 | Half switching cycle, in clocks |
| phaseCmd | input | 8 | Lag of the C/D leg in clocks; also the no-load control level |
| deadAB | input | 6 | Dead-time base of the A/B leg, in clocks |
| deadCD | input | 6 | Dead-time base of the C/D leg, in clocks |
| curCode | input | 5 | Load-current code (16 = full scale) |
| adsCode | input | 5 | Adaptive-set code that reduces the current-driven shortening |
| outA | output | 1 | A/B leg high-side command |
| outB | output | 1 | A/B leg low-side command |
| outC | output | 1 | C/D leg high-side command |
| outD | output | 1 | C/D leg low-side command |

## Verification
The checks on dead-time non-overlap and the latching window assume that a dead base is below the effective period it is latched with. With a larger base, a leg stays off for the whole half-cycle. The random stimulus draws each dead base below the clamped period drawn in the same step, and it sometimes draws periods under 4 and phase commands above the period to exercise the clamps. Inputs change at random points within a cycle, so the outputs must show that a setting waits for the cycle boundary.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  // Strobes from the sequencing control to the waveform datapath
  typedef struct packed {
    logic run;     // timebase running
    logic load;    // latch new settings this clock
    logic noLoad;  // light-demand lockout active
  } psfb_strobe_t;
endpackage

// File: rtl/psfb_ctrl.sv
module psfb_ctrl
  import psfb_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PER_MIN = 4,
  parameter int NL_OFF  = 8,
  parameter int NL_ON   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] phaseCmd,
  output psfb_strobe_t     strb,
  output logic [CNT_W:0]   tPos,
  output logic [CNT_W-1:0] perReg,
  output logic [CNT_W-1:0] perNext
);
  localparam int T_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] PER_MIN_C = CNT_W'(PER_MIN);
  localparam logic [CNT_W-1:0] NL_OFF_C  = CNT_W'(NL_OFF);
  localparam logic [CNT_W-1:0] NL_ON_C   = CNT_W'(NL_ON);

  logic [T_W-1:0] lastT;
  logic           loadNow;
  logic           noLoad;

  assign perNext = (period < PER_MIN_C) ? PER_MIN_C : period;
  assign lastT   = {perReg, 1'b0} - T_W'(1);
  assign loadNow = !en || (tPos == lastT);

  assign strb.run    = en;
  assign strb.load   = loadNow;
  assign strb.noLoad = noLoad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tPos   <= '0;
      perReg <= PER_MIN_C;
      noLoad <= 1'b1;
    end else begin
      tPos <= loadNow ? '0 : tPos + T_W'(1);
      if (loadNow) begin
        perReg <= perNext;
        if (phaseCmd < NL_OFF_C)     noLoad <= 1'b1;
        else if (phaseCmd > NL_ON_C) noLoad <= 1'b0;
      end
    end
  end

  // The cycle position never passes the end of the switching cycle
  assert_tpos_in_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tPos <= lastT);

  // The latched period never drops under the floor
  assert_period_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    perReg >= PER_MIN_C);
endmodule

// File: rtl/psfb_dead.sv
module psfb_dead #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            allow,
  input  logic            raw,
  input  logic [DT_W-1:0] dt,
  output logic            outHi,
  output logic            outLo
);
  localparam logic [DT_W-1:0] EL_MAX = '1;

  logic            prevRaw;
  logic [DT_W-1:0] elCnt, steady, elNext;
  logic            settled;

  // Clocks the raw level has held so far, zero on the clock it changes
  assign steady  = (raw == prevRaw) ? elCnt : '0;
  assign elNext  = (steady == EL_MAX) ? steady : steady + DT_W'(1);
  assign settled = (steady >= dt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevRaw <= 1'b0;
      elCnt   <= '0;
      outHi   <= 1'b0;
      outLo   <= 1'b0;
    end else if (!run) begin
      prevRaw <= 1'b0;
      elCnt   <= '0;
      outHi   <= 1'b0;
      outLo   <= 1'b0;
    end else begin
      prevRaw <= raw;
      elCnt   <= elNext;
      outHi   <= raw && settled && allow;
      outLo   <= !raw && settled && allow;
    end
  end

  // Both switches of a leg are never commanded on together
  assert_leg_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(outHi && outLo));
endmodule

// File: rtl/psfb_datapath.sv
module psfb_datapath
  import psfb_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DT_W     = 6,
  parameter int CUR_W    = 5,
  parameter int CUR_FULL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  psfb_strobe_t     strb,
  input  logic [CNT_W:0]   tPos,
  input  logic [CNT_W-1:0] perReg,
  input  logic [CNT_W-1:0] perNext,
  input  logic [CNT_W-1:0] phaseCmd,
  input  logic [DT_W-1:0]  deadAB,
  input  logic [DT_W-1:0]  deadCD,
  input  logic [CUR_W-1:0] curCode,
  input  logic [CUR_W-1:0] adsCode,
  output logic [1:0]       legHi,
  output logic [1:0]       legLo
);
  localparam int W2     = CNT_W + 2;
  localparam int PROD_W = DT_W + CUR_W + 3;
  localparam logic [CUR_W-1:0] FULL_C = CUR_W'(CUR_FULL);

  function automatic logic [DT_W-1:0] effDead(input logic [DT_W-1:0]  base,
                                              input logic [CUR_W-1:0] cur,
                                              input logic [CUR_W-1:0] ads);
    logic [CUR_W-1:0]  adsLim, diff, diffCap;
    logic [PROD_W-1:0] num, den;
    adsLim  = (ads > cur) ? cur : ads;
    diff    = cur - adsLim;
    diffCap = (diff > FULL_C) ? FULL_C : diff;
    num     = PROD_W'(base) * PROD_W'(FULL_C);
    den     = PROD_W'(FULL_C) + PROD_W'(diffCap) * PROD_W'(3);
    return DT_W'(num / den);
  endfunction

  logic [CNT_W-1:0]       shiftR;
  logic [1:0][DT_W-1:0]   dtR;
  logic [W2-1:0]          tW, sW, pW, lagPos;
  logic [1:0]             rawLeg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftR <= '0;
      dtR    <= '0;
    end else if (strb.load) begin
      shiftR <= (phaseCmd > perNext) ? perNext : phaseCmd;
      dtR[0] <= effDead(deadAB, curCode, adsCode);
      dtR[1] <= effDead(deadCD, curCode, adsCode);
    end
  end

  assign tW     = W2'(tPos);
  assign sW     = W2'(shiftR);
  assign pW     = W2'(perReg);
  assign lagPos = (tW >= sW) ? (tW - sW) : (tW + (pW << 1) - sW);
  assign rawLeg[0] = (tW < pW);
  assign rawLeg[1] = (lagPos < pW);

  for (genvar g = 0; g < 2; g++) begin : g_leg
    psfb_dead #(.DT_W(DT_W)) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (strb.run),
      .allow (!strb.noLoad),
      .raw   (rawLeg[g]),
      .dt    (dtR[g]),
      .outHi (legHi[g]),
      .outLo (legLo[g])
    );
  end

  // The latched lag never exceeds the latched half cycle
  assert_shift_clamped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shiftR <= perReg);
endmodule

// File: rtl/psfb_gate_gen.sv
module psfb_gate_gen
  import psfb_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DT_W     = 6,
  parameter int CUR_W    = 5,
  parameter int CUR_FULL = 16,
  parameter int PER_MIN  = 4,
  parameter int NL_OFF   = 8,
  parameter int NL_ON    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] phaseCmd,
  input  logic [DT_W-1:0]  deadAB,
  input  logic [DT_W-1:0]  deadCD,
  input  logic [CUR_W-1:0] curCode,
  input  logic [CUR_W-1:0] adsCode,
  output logic             outA,
  output logic             outB,
  output logic             outC,
  output logic             outD
);
  psfb_strobe_t     strb;
  logic [CNT_W:0]   tPos;
  logic [CNT_W-1:0] perReg, perNext;
  logic [1:0]       legHi, legLo;

  psfb_ctrl #(.CNT_W(CNT_W), .PER_MIN(PER_MIN), .NL_OFF(NL_OFF), .NL_ON(NL_ON)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .phaseCmd(phaseCmd),
    .strb(strb), .tPos(tPos), .perReg(perReg), .perNext(perNext)
  );

  psfb_datapath #(.CNT_W(CNT_W), .DT_W(DT_W), .CUR_W(CUR_W), .CUR_FULL(CUR_FULL)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .tPos(tPos), .perReg(perReg),
    .perNext(perNext), .phaseCmd(phaseCmd), .deadAB(deadAB), .deadCD(deadCD),
    .curCode(curCode), .adsCode(adsCode), .legHi(legHi), .legLo(legLo)
  );

  assign outA = legHi[0];
  assign outB = legLo[0];
  assign outC = legHi[1];
  assign outD = legLo[1];

  // Disable clears every gate command on the following clock
  assert_disable_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(outA || outB || outC || outD));

  // Light-demand lockout holds every gate command low
  assert_noload_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.noLoad |=> !(outA || outB || outC || outD));
endmodule

// File: tb/psfb_gate_gen_tb.sv
module psfb_gate_gen_tb;
  localparam int CNT_W = 8, DT_W = 6, CUR_W = 5, CUR_FULL = 16;
  localparam int PER_MIN = 4, NL_OFF = 8, NL_ON = 12;
  localparam int EL_MAX = (1 << DT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [CNT_W-1:0] period = 8'd60, phaseCmd = 8'd30;
  logic [DT_W-1:0]  deadAB = '0, deadCD = '0;
  logic [CUR_W-1:0] curCode = '0, adsCode = '0;
  logic outA, outB, outC, outD;

  int errors = 0, checks = 0;
  bit chkOn = 0;
  string cycReq = "R1";

  always #5 clk = ~clk;

  psfb_gate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .phaseCmd(phaseCmd),
    .deadAB(deadAB), .deadCD(deadCD), .curCode(curCode), .adsCode(adsCode),
    .outA(outA), .outB(outB), .outC(outC), .outD(outD)
  );

  function automatic int deff(int base, int cur, int ads);
    int a, k;
    a = (ads > cur) ? cur : ads;
    k = cur - a;
    if (k > CUR_FULL) k = CUR_FULL;
    return (base * CUR_FULL) / (CUR_FULL + 3 * k);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle reference built from the requirements
  int mT = 0, mP = PER_MIN, mS = 0, mNl = 1;
  int mDt[2], mPrev[2], mEl[2], mHi[2], mLo[2], mRaw[2];
  int mSt, mNp, mU;
  bit mLd;
  initial for (int i = 0; i < 2; i++) begin
    mDt[i] = 0; mPrev[i] = 0; mEl[i] = 0; mHi[i] = 0; mLo[i] = 0; mRaw[i] = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mT = 0; mP = PER_MIN; mS = 0; mNl = 1;
      for (int i = 0; i < 2; i++) begin
        mDt[i] = 0; mPrev[i] = 0; mEl[i] = 0; mHi[i] = 0; mLo[i] = 0;
      end
    end else begin
      mRaw[0] = (mT < mP) ? 1 : 0;
      mU = (mT >= mS) ? mT - mS : mT + 2 * mP - mS;
      mRaw[1] = (mU < mP) ? 1 : 0;
      for (int i = 0; i < 2; i++) begin
        if (!en) begin
          mPrev[i] = 0; mEl[i] = 0; mHi[i] = 0; mLo[i] = 0;
        end else begin
          mSt = (mRaw[i] == mPrev[i]) ? mEl[i] : 0;
          mHi[i] = (mRaw[i] == 1 && mSt >= mDt[i] && mNl == 0) ? 1 : 0;
          mLo[i] = (mRaw[i] == 0 && mSt >= mDt[i] && mNl == 0) ? 1 : 0;
          mPrev[i] = mRaw[i];
          mEl[i] = (mSt >= EL_MAX) ? EL_MAX : mSt + 1;
        end
      end
      mLd = !en || (mT == 2 * mP - 1);
      mT = mLd ? 0 : mT + 1;
      if (mLd) begin
        mNp = (int'(period) < PER_MIN) ? PER_MIN : int'(period);
        mP = mNp;
        mS = (int'(phaseCmd) > mNp) ? mNp : int'(phaseCmd);
        mDt[0] = deff(int'(deadAB), int'(curCode), int'(adsCode));
        mDt[1] = deff(int'(deadCD), int'(curCode), int'(adsCode));
        if (int'(phaseCmd) < NL_OFF) mNl = 1;
        else if (int'(phaseCmd) > NL_ON) mNl = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (chkOn) begin
      chk(cycReq, int'({outA, outB, outC, outD}), mHi[0] * 8 + mLo[0] * 4 + mHi[1] * 2 + mLo[1]);
      chk("R2 leg overlap", ((outA && outB) || (outC && outD)) ? 1 : 0, 0);
    end
  end

  function automatic logic sig(int w);
    case (w)
      0: return outA;
      1: return outB;
      2: return outC;
      3: return outD;
      4: return !outA;
      5: return !outB;
      6: return !outC;
      default: return !outD;
    endcase
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Clocks from a rise of w1 to the next rise of w2 (-1 on timeout)
  task automatic measLag(int w1, int w2, output int n);
    logic p1, p2;
    bit got;
    int cnt;
    p1 = sig(w1); p2 = sig(w2); got = 0; cnt = 0; n = -1;
    for (int g = 0; g < 3000 && n < 0; g++) begin
      @(negedge clk);
      if (!got) begin
        if (!p1 && sig(w1)) got = 1;
      end else cnt++;
      if (got && !p2 && sig(w2) && (w1 != w2 || cnt > 0)) n = cnt;
      p1 = sig(w1); p2 = sig(w2);
    end
  endtask

  int n, firstA;

  initial begin
    void'($urandom(32'd2024));
    cyc(3);
    chk("R9 reset outputs low", int'({outA, outB, outC, outD}), 0);
    rst_n = 1'b1;
    cyc(2);
    chkOn = 1;

    // R5: dead time scaled by the current code
    period = 8'd60; phaseCmd = 8'd30; deadAB = 6'd40; deadCD = 6'd40;
    curCode = 5'd16; adsCode = 5'd0; en = 1'b1;
    cyc(300);
    measLag(4, 1, n); chk("R5 AB dead at full current", n, deff(40, 16, 0));
    measLag(6, 3, n); chk("R5 CD dead at full current", n, 10);
    curCode = 5'd8;
    cyc(260);
    measLag(4, 1, n); chk("R5 AB dead at half current", n, 16);

    // R6: adaptive set at or above current removes the scaling
    adsCode = 5'd20;
    cyc(260);
    measLag(4, 1, n); chk("R6 ads above cur", n, 40);
    curCode = 5'd20;
    cyc(260);
    measLag(6, 3, n); chk("R6 ads equal cur", n, 40);

    // R4: zero base defeats the dead time; per-leg settings
    deadAB = 6'd0; deadCD = 6'd5; curCode = 5'd0; adsCode = 5'd0;
    cyc(260);
    measLag(4, 1, n); chk("R4 AB defeated dead time", n, 0);
    measLag(6, 3, n); chk("R4 CD dead time", n, 5);

    // R3: lag of the second leg
    deadAB = 6'd4; deadCD = 6'd4; phaseCmd = 8'd17;
    cyc(260);
    measLag(0, 2, n); chk("R3 lag 17", n, 17);
    measLag(1, 3, n); chk("R3 OUTD lag 17", n, 17);
    phaseCmd = 8'd200;
    cyc(260);
    measLag(0, 2, n); chk("R3 lag clamped to period", n, 60);
    phaseCmd = 8'd12;
    cyc(260);
    measLag(0, 2, n); chk("R3 lag 12", n, 12);

    // R1: cycle length and high time
    measLag(0, 0, n); chk("R1 OUTA repeat", n, 120);
    measLag(0, 4, n); chk("R1 OUTA high time", n, 56);

    // R7: mid-cycle change waits for the boundary
    phaseCmd = 8'd17;
    cyc(260);
    begin
      logic pa, pc;
      int cnt;
      bit got;
      pa = outA; pc = outC; got = 0; cnt = 0; n = -1;
      for (int g = 0; g < 3000 && n < 0; g++) begin
        @(negedge clk);
        if (!got) begin
          if (!pa && outA) got = 1;
        end else begin
          cnt++;
          if (cnt == 10) phaseCmd = 8'd40;
        end
        if (got && !pc && outC) n = cnt;
        pa = outA; pc = outC;
      end
      chk("R7 mid-cycle phase change ignored", n, 17);
    end
    cyc(260);
    measLag(0, 2, n); chk("R7 new phase after boundary", n, 40);

    // R10: period floor
    period = 8'd2; deadAB = 6'd0; deadCD = 6'd0; phaseCmd = 8'd30;
    cyc(260);
    measLag(0, 0, n); chk("R10 period clamped to 4", n, 8);
    period = 8'd60;
    cyc(260);

    // R8: no-load hysteresis
    phaseCmd = 8'd5;
    cyc(260);
    n = 0;
    for (int i = 0; i < 130; i++) begin
      @(negedge clk);
      if (outA || outB || outC || outD) n++;
    end
    chk("R8 off below low threshold", n, 0);
    phaseCmd = 8'd10;
    cyc(260);
    n = 0;
    for (int i = 0; i < 130; i++) begin
      @(negedge clk);
      if (outA || outB || outC || outD) n++;
    end
    chk("R8 held off inside band", n, 0);
    phaseCmd = 8'd20;
    cyc(260);
    n = 0;
    for (int i = 0; i < 130; i++) begin
      @(negedge clk);
      if (outA) n++;
    end
    chk("R8 released above high threshold", (n > 0) ? 1 : 0, 1);

    // R9: disable and restart with OUTA first
    en = 1'b0;
    @(negedge clk);
    chk("R9 disable clears outputs", int'({outA, outB, outC, outD}), 0);
    deadAB = 6'd4;
    cyc(5);
    en = 1'b1;
    firstA = -1;
    for (int i = 0; i < 300 && firstA < 0; i++) begin
      @(negedge clk);
      if (outA) firstA = 1;
      else if (outB) firstA = 0;
    end
    chk("R9 OUTA first after enable", firstA, 1);

    // R7: random settings changed at arbitrary points in the cycle
    cycReq = "R7 cycle reference";
    for (int s = 0; s < 40; s++) begin
      int p, pe, m;
      p  = (($urandom % 8) == 0) ? 1 + int'($urandom % 7) : 8 + int'($urandom % 73);
      pe = (p < PER_MIN) ? PER_MIN : p;
      m  = (pe - 1 < EL_MAX) ? pe - 1 : EL_MAX;
      period   = CNT_W'(p);
      phaseCmd = CNT_W'($urandom % (p + 11));
      deadAB   = DT_W'($urandom % (m + 1));
      deadCD   = DT_W'($urandom % (m + 1));
      curCode  = CUR_W'($urandom % 32);
      adsCode  = CUR_W'($urandom % 32);
      en       = (($urandom % 10) != 0);
      cyc(300 + int'($urandom % 300));
    end

    chkOn = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule